// File: doc/BRIEF.md
# UART Host Register Front End

This block is the processor-facing register file of a 16450/16550-style serial port. A host drives a 3-bit register offset together with single-cycle read and write strobes. The block steers each access to the correct register: receive buffer, transmit holding register, interrupt enable, interrupt identification, FIFO control, line control, modem control, line status, modem status, scratch byte, or one of the two baud divisor bytes. Bit 7 of the line control register switches offsets 0 and 1 over to the divisor bytes. Several offsets select one register on read and a different one on write.

The serial shifters are not part of this block. They attach through simple handshakes. A receiver presents a byte with a one-cycle valid pulse and its error flags. A transmitter reports through `tx_ready` that it can take a byte, and the block hands the byte over with a one-cycle `tx_load` pulse. Four modem input levels feed the modem status register. The block prioritises the pending interrupt sources and drives a registered interrupt pin. Modem control bit 3 gates that pin.

Top module: `uart_host_regs`

## Requirements
- R1: With line control bit 7 at 0, a read of offset 0 returns the last received byte and a write to offset 0 loads the transmit holding register.
- R2: With line control bit 7 at 0, offset 1 reads and writes the interrupt enable register. Bit 0 enables received data, bit 1 transmit holding empty, bit 2 line status and bit 3 modem status. Bits 7:4 read as 0.
- R3: With line control bit 7 at 1, offset 0 reads and writes the divisor low byte and offset 1 the divisor high byte. The `divisor` output holds any 16-bit value from 1 to 65535 unchanged until the next divisor write. These writes leave the interrupt enable register untouched.
- R4: Offset 2 returns interrupt identification on read and loads `fifo_ctrl` on write, for either value of line control bit 7.
- R5: Offsets 3 to 7 are line control, modem control (5 bits), line status, modem status and scratch, whatever line control bit 7 is. Writes to line status and modem status have no effect.
- R6: `irq` is high one cycle after an enabled source is pending while modem control bit 3 is 1. It is low one cycle after that bit is 0.
- R7: A received byte sets line status bit 0 (data ready). A read of the receive buffer clears it. A byte that arrives while data ready is set sets overrun (bit 1). The receiver's parity, framing and break flags set bits 2, 3 and 4.
- R8: A write to the transmit holding register clears line status bit 5 (holding empty) and bit 6 (transmitter empty). Once `tx_ready` is high the byte leaves on a single `tx_load` pulse and bit 5 returns to 1. Bit 6 is bit 5 AND `tx_ready`.
- R9: Interrupt identification reads 0x06 for a line-status error, 0x04 for data ready, 0x02 for holding empty and 0x00 for a modem-status change, in that priority order. It reads 0x01 when no enabled source is pending.
- R10: A line status read clears bits 1 to 4. A modem status read clears the change bits 3:0. Bits 7:4 of modem status mirror `modem_in` (bit 0 clear-to-send, 1 data-set-ready, 2 ring, 3 carrier). The change bits flag a toggle of bits 0, 1 and 3 and a 1-to-0 fall of ring.
- R11: Reset clears every control register, the divisor and the scratch byte. After reset, interrupt identification reads 0x01 and line status reads 0x60 with `tx_ready` high.
- R12: Read data appears on `rdata` on the clock edge that samples `rd_en` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register offset |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request, gated by modem control bit 3 |
| rx_valid | input | 1 | Receiver presents a byte this cycle |
| rx_byte | input | 8 | Received byte |
| rx_perr | input | 1 | Parity error on the presented byte |
| rx_ferr | input | 1 | Framing error on the presented byte |
| rx_brk | input | 1 | Break seen on the presented byte |
| tx_ready | input | 1 | Transmit shifter can accept a byte |
| tx_load | output | 1 | One-cycle pulse handing `tx_byte` to the shifter |
| tx_byte | output | 8 | Byte handed to the transmit shifter |
| modem_in | input | 4 | Modem input levels (CTS, DSR, RI, DCD from bit 0) |
| divisor | output | 16 | Baud divisor, high byte over low byte |
| line_ctrl | output | 8 | Line control register |
| modem_ctrl | output | 5 | Modem control register |
| fifo_ctrl | output | 8 | Last value written to FIFO control |

## Verification
Some properties can be judged on every cycle, and the checker watches those. `irq` must stay low whenever modem control bit 3 was 0 on the previous cycle, and must follow a pending source once that bit was 1. The divisor may change only after a divisor-byte write. A receive-buffer read must drop data ready, and a transmit write must drop holding empty. Each `tx_load` must be a single pulse, and transmitter empty must never be set without holding empty. Other behaviour needs a sequence of accesses, and only the bench scenarios can show it. That covers the source order in the identification code, which register each offset selects in each overlay, the clear-on-read side effects of status reads, overrun on a second byte, and the reset read-back values.

// File: rtl/uart_host_pkg.sv
package uart_host_pkg;
  localparam int DATA_W  = 8;
  localparam int OFS_W   = 3;
  localparam int DIV_W   = 2 * DATA_W;
  localparam int IER_W   = 4;
  localparam int MCR_W   = 5;
  localparam int MODEM_W = 4;
  localparam int ERR_W   = 4;

  localparam logic [OFS_W-1:0] OFS_DATA = 3'd0;
  localparam logic [OFS_W-1:0] OFS_IEN  = 3'd1;
  localparam logic [OFS_W-1:0] OFS_IDF  = 3'd2;
  localparam logic [OFS_W-1:0] OFS_LCTL = 3'd3;
  localparam logic [OFS_W-1:0] OFS_MCTL = 3'd4;
  localparam logic [OFS_W-1:0] OFS_LSTA = 3'd5;
  localparam logic [OFS_W-1:0] OFS_MSTA = 3'd6;
  localparam logic [OFS_W-1:0] OFS_SCR  = 3'd7;

  localparam int LCR_OVERLAY_BIT = 7;
  localparam int MCR_GATE_BIT    = 3;

  localparam logic [DATA_W-1:0] ID_NONE = 8'h01;
  localparam logic [DATA_W-1:0] ID_LINE = 8'h06;
  localparam logic [DATA_W-1:0] ID_RXD  = 8'h04;
  localparam logic [DATA_W-1:0] ID_TXE  = 8'h02;
  localparam logic [DATA_W-1:0] ID_MDM  = 8'h00;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_RXBUF, SEL_TXHOLD, SEL_IEN, SEL_DIVLO, SEL_DIVHI,
    SEL_IDENT, SEL_FCTL, SEL_LCTL, SEL_MCTL, SEL_LSTA, SEL_MSTA, SEL_SCR
  } reg_sel_e;
endpackage

// File: rtl/uart_host_decode.sv
module uart_host_decode
  import uart_host_pkg::*;
(
  input  logic [OFS_W-1:0] addr,
  input  logic             overlay,
  output reg_sel_e         rd_sel,
  output reg_sel_e         wr_sel
);
  always_comb begin
    rd_sel = SEL_NONE;
    wr_sel = SEL_NONE;
    case (addr)
      OFS_DATA: begin
        rd_sel = overlay ? SEL_DIVLO : SEL_RXBUF;
        wr_sel = overlay ? SEL_DIVLO : SEL_TXHOLD;
      end
      OFS_IEN: begin
        rd_sel = overlay ? SEL_DIVHI : SEL_IEN;
        wr_sel = overlay ? SEL_DIVHI : SEL_IEN;
      end
      OFS_IDF: begin
        rd_sel = SEL_IDENT;
        wr_sel = SEL_FCTL;
      end
      OFS_LCTL: begin
        rd_sel = SEL_LCTL;
        wr_sel = SEL_LCTL;
      end
      OFS_MCTL: begin
        rd_sel = SEL_MCTL;
        wr_sel = SEL_MCTL;
      end
      OFS_LSTA: begin
        rd_sel = SEL_LSTA;
        wr_sel = SEL_LSTA;
      end
      OFS_MSTA: begin
        rd_sel = SEL_MSTA;
        wr_sel = SEL_MSTA;
      end
      default: begin
        rd_sel = SEL_SCR;
        wr_sel = SEL_SCR;
      end
    endcase
  end
endmodule

// File: rtl/uart_host_line_status.sv
module uart_host_line_status
  import uart_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_perr,
  input  logic              rx_ferr,
  input  logic              rx_brk,
  input  logic              rxbuf_rd,
  input  logic              lsta_rd,
  input  logic              hold_wr,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] rxbuf,
  output logic [DATA_W-1:0] lsta,
  output logic              tx_load,
  output logic [DATA_W-1:0] tx_byte
);
  logic              ready_q;
  logic [ERR_W-1:0]  err_q;
  logic [ERR_W-1:0]  err_keep;
  logic [ERR_W-1:0]  err_new;
  logic              hold_empty_q;
  logic [DATA_W-1:0] hold_q;
  logic              shift_empty;

  // err bit order: {break, framing, parity, overrun}
  assign err_keep    = lsta_rd ? '0 : err_q;
  assign err_new     = rx_valid ? {rx_brk, rx_ferr, rx_perr, ready_q & ~rxbuf_rd} : '0;
  assign shift_empty = hold_empty_q & tx_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      rxbuf   <= '0;
      ready_q <= 1'b0;
      err_q   <= '0;
    end else begin
      err_q <= err_keep | err_new;
      if (rx_valid) begin
        rxbuf   <= rx_byte;
        ready_q <= 1'b1;
      end else if (rxbuf_rd) begin
        ready_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q       <= '0;
      hold_empty_q <= 1'b1;
      tx_load      <= 1'b0;
      tx_byte      <= '0;
    end else begin
      tx_load <= 1'b0;
      if (hold_wr) begin
        hold_q       <= hold_data;
        hold_empty_q <= 1'b0;
      end else if (!hold_empty_q && tx_ready) begin
        tx_load      <= 1'b1;
        tx_byte      <= hold_q;
        hold_empty_q <= 1'b1;
      end
    end
  end

  assign lsta = {1'b0, shift_empty, hold_empty_q, err_q, ready_q};
endmodule

// File: rtl/uart_host_modem_status.sv
module uart_host_modem_status
  import uart_host_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [MODEM_W-1:0] modem_in,
  input  logic               msta_rd,
  output logic [DATA_W-1:0]  msta
);
  localparam int RING_BIT = 2;

  logic [MODEM_W-1:0] level_q;
  logic [MODEM_W-1:0] change_q;
  logic [MODEM_W-1:0] change_now;

  for (genvar gi = 0; gi < MODEM_W; gi++) begin : g_edge
    if (gi == RING_BIT) begin : g_fall
      assign change_now[gi] = level_q[gi] & ~modem_in[gi];
    end else begin : g_toggle
      assign change_now[gi] = level_q[gi] ^ modem_in[gi];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q  <= modem_in;
      change_q <= '0;
    end else begin
      level_q  <= modem_in;
      change_q <= (msta_rd ? '0 : change_q) | change_now;
    end
  end

  assign msta = {level_q, change_q};
endmodule

// File: rtl/uart_host_int_prio.sv
module uart_host_int_prio
  import uart_host_pkg::*;
(
  input  logic [IER_W-1:0]  ien,
  input  logic              rx_ready,
  input  logic              hold_empty,
  input  logic              line_err,
  input  logic              modem_chg,
  output logic [DATA_W-1:0] ident,
  output logic              any_pend
);
  logic [IER_W-1:0] pend;

  // pend order: {modem, line, hold empty, rx data}
  assign pend     = ien & {modem_chg, line_err, hold_empty, rx_ready};
  assign any_pend = |pend;

  always_comb begin
    if (pend[2])      ident = ID_LINE;
    else if (pend[0]) ident = ID_RXD;
    else if (pend[1]) ident = ID_TXE;
    else if (pend[3]) ident = ID_MDM;
    else              ident = ID_NONE;
  end
endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
  import uart_host_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [OFS_W-1:0]   addr,
  input  logic               rd_en,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               irq,
  input  logic               rx_valid,
  input  logic [DATA_W-1:0]  rx_byte,
  input  logic               rx_perr,
  input  logic               rx_ferr,
  input  logic               rx_brk,
  input  logic               tx_ready,
  output logic               tx_load,
  output logic [DATA_W-1:0]  tx_byte,
  input  logic [MODEM_W-1:0] modem_in,
  output logic [DIV_W-1:0]   divisor,
  output logic [DATA_W-1:0]  line_ctrl,
  output logic [MCR_W-1:0]   modem_ctrl,
  output logic [DATA_W-1:0]  fifo_ctrl
);
  reg_sel_e          rd_sel;
  reg_sel_e          wr_sel;
  logic [IER_W-1:0]  ien_q;
  logic [DATA_W-1:0] scr_q;
  logic [DATA_W-1:0] div_lo_q;
  logic [DATA_W-1:0] div_hi_q;
  logic [DATA_W-1:0] rxbuf_val;
  logic [DATA_W-1:0] lsr_val;
  logic [DATA_W-1:0] msr_val;
  logic [DATA_W-1:0] ident_val;
  logic [DATA_W-1:0] rd_mux;
  logic              int_any;
  logic              rxbuf_rd;
  logic              lsta_rd;
  logic              msta_rd;
  logic              hold_wr;

  uart_host_decode u_decode (
    .addr    (addr),
    .overlay (line_ctrl[LCR_OVERLAY_BIT]),
    .rd_sel  (rd_sel),
    .wr_sel  (wr_sel)
  );

  assign rxbuf_rd = rd_en && (rd_sel == SEL_RXBUF);
  assign lsta_rd  = rd_en && (rd_sel == SEL_LSTA);
  assign msta_rd  = rd_en && (rd_sel == SEL_MSTA);
  assign hold_wr  = wr_en && (wr_sel == SEL_TXHOLD);

  uart_host_line_status u_line (
    .clk       (clk),
    .rst       (rst),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .rx_perr   (rx_perr),
    .rx_ferr   (rx_ferr),
    .rx_brk    (rx_brk),
    .rxbuf_rd  (rxbuf_rd),
    .lsta_rd   (lsta_rd),
    .hold_wr   (hold_wr),
    .hold_data (wdata),
    .tx_ready  (tx_ready),
    .rxbuf     (rxbuf_val),
    .lsta      (lsr_val),
    .tx_load   (tx_load),
    .tx_byte   (tx_byte)
  );

  uart_host_modem_status u_modem (
    .clk      (clk),
    .rst      (rst),
    .modem_in (modem_in),
    .msta_rd  (msta_rd),
    .msta     (msr_val)
  );

  uart_host_int_prio u_prio (
    .ien        (ien_q),
    .rx_ready   (lsr_val[0]),
    .hold_empty (lsr_val[5]),
    .line_err   (|lsr_val[4:1]),
    .modem_chg  (|msr_val[MODEM_W-1:0]),
    .ident      (ident_val),
    .any_pend   (int_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q      <= '0;
      line_ctrl  <= '0;
      modem_ctrl <= '0;
      fifo_ctrl  <= '0;
      scr_q      <= '0;
      div_lo_q   <= '0;
      div_hi_q   <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_IEN:   ien_q      <= wdata[IER_W-1:0];
        SEL_DIVLO: div_lo_q   <= wdata;
        SEL_DIVHI: div_hi_q   <= wdata;
        SEL_FCTL:  fifo_ctrl  <= wdata;
        SEL_LCTL:  line_ctrl  <= wdata;
        SEL_MCTL:  modem_ctrl <= wdata[MCR_W-1:0];
        SEL_SCR:   scr_q      <= wdata;
        default:   ;
      endcase
    end
  end

  assign divisor = {div_hi_q, div_lo_q};

  always_comb begin
    case (rd_sel)
      SEL_RXBUF: rd_mux = rxbuf_val;
      SEL_IEN:   rd_mux = {{(DATA_W-IER_W){1'b0}}, ien_q};
      SEL_DIVLO: rd_mux = div_lo_q;
      SEL_DIVHI: rd_mux = div_hi_q;
      SEL_IDENT: rd_mux = ident_val;
      SEL_LCTL:  rd_mux = line_ctrl;
      SEL_MCTL:  rd_mux = {{(DATA_W-MCR_W){1'b0}}, modem_ctrl};
      SEL_LSTA:  rd_mux = lsr_val;
      SEL_MSTA:  rd_mux = msr_val;
      SEL_SCR:   rd_mux = scr_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_mux;
      irq <= modem_ctrl[MCR_GATE_BIT] & int_any;
    end
  end
endmodule

// File: rtl/uart_host_regs_chk.sv
module uart_host_regs_chk
  import uart_host_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [OFS_W-1:0]  addr,
  input logic              rd_en,
  input logic              wr_en,
  input logic              rx_valid,
  input logic              irq,
  input logic              int_any,
  input logic              tx_load,
  input logic [DIV_W-1:0]  divisor,
  input logic [DATA_W-1:0] line_ctrl,
  input logic [MCR_W-1:0]  modem_ctrl,
  input logic [DATA_W-1:0] lsr_val
);
  AST_IRQ_GATED_OFF: assert property (@(posedge clk) disable iff (rst)
    !$past(modem_ctrl[MCR_GATE_BIT]) |-> !irq); // R6

  AST_IRQ_FOLLOWS_PEND: assert property (@(posedge clk) disable iff (rst)
    $past(modem_ctrl[MCR_GATE_BIT] && int_any) |-> irq); // R6

  AST_DIVISOR_HELD: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && line_ctrl[LCR_OVERLAY_BIT] && (addr == OFS_DATA || addr == OFS_IEN))
    |=> $stable(divisor)); // R3

  AST_RXBUF_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == OFS_DATA && !line_ctrl[LCR_OVERLAY_BIT] && !rx_valid)
    |=> !lsr_val[0]); // R7

  AST_RX_SETS_READY: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> lsr_val[0]); // R7

  AST_HOLD_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_DATA && !line_ctrl[LCR_OVERLAY_BIT]) |=> !lsr_val[5]); // R8

  AST_TX_LOAD_PULSE: assert property (@(posedge clk) disable iff (rst)
    tx_load |=> !tx_load); // R8

  AST_TEMT_NEEDS_THRE: assert property (@(posedge clk) disable iff (rst)
    lsr_val[6] |-> lsr_val[5]); // R8
endmodule

bind uart_host_regs uart_host_regs_chk u_chk (.*);

// File: tb/uart_host_regs_tb.sv
`timescale 1ns/1ps
module uart_host_regs_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  addr = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_perr = 1'b0;
  logic        rx_ferr = 1'b0;
  logic        rx_brk = 1'b0;
  logic        tx_ready = 1'b1;
  logic        tx_load;
  logic [7:0]  tx_byte;
  logic [3:0]  modem_in = '0;
  logic [15:0] divisor;
  logic [7:0]  line_ctrl;
  logic [4:0]  modem_ctrl;
  logic [7:0]  fifo_ctrl;

  int n_chk  = 0;
  int n_fail = 0;
  int tx_cnt = 0;
  logic [7:0] tx_last = '0;

  always #10 clk = ~clk;

  uart_host_regs u_dut (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .irq(irq), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk),
    .tx_ready(tx_ready), .tx_load(tx_load), .tx_byte(tx_byte),
    .modem_in(modem_in), .divisor(divisor), .line_ctrl(line_ctrl),
    .modem_ctrl(modem_ctrl), .fifo_ctrl(fifo_ctrl)
  );

  always @(posedge clk) if (tx_load) begin
    tx_cnt  <= tx_cnt + 1;
    tx_last <= tx_byte;
  end

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic rd_chk(input string req, input string what,
                        input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    check(req, what, {8'h00, d}, {8'h00, exp});
  endtask

  task automatic rx_push(input logic [7:0] b, input logic pe);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b; rx_perr = pe;
    @(negedge clk); rx_valid = 1'b0; rx_perr = 1'b0;
  endtask

  task automatic t_reset;
    check("R11", "divisor after reset", divisor, 16'h0000);
    check("R11", "irq after reset", {15'h0, irq}, 16'h0);
    rd_chk("R11", "line status after reset", 3'd5, 8'h60);
    rd_chk("R11", "ident after reset", 3'd2, 8'h01);
    rd_chk("R11", "ien after reset", 3'd1, 8'h00);
    rd_chk("R11", "line ctrl after reset", 3'd3, 8'h00);
    rd_chk("R11", "modem ctrl after reset", 3'd4, 8'h00);
    rd_chk("R11", "scratch after reset", 3'd7, 8'h00);
  endtask

  task automatic t_divisor;
    wr(3'd3, 8'h80);
    wr(3'd0, 8'h01); wr(3'd1, 8'h00);
    check("R3", "divisor min", divisor, 16'h0001);
    rd_chk("R3", "divisor low readback", 3'd0, 8'h01);
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);
    check("R3", "divisor max", divisor, 16'hFFFF);
    rd_chk("R3", "divisor high readback", 3'd1, 8'hFF);
    wr(3'd3, 8'h03);
    rd_chk("R3", "ien untouched by divisor write", 3'd1, 8'h00);
    check("R3", "divisor held", divisor, 16'hFFFF);
    rd_chk("R5", "line ctrl readback", 3'd3, 8'h03);
    wr(3'd1, 8'hFF);
    rd_chk("R2", "ien upper bits zero", 3'd1, 8'h0F);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_offsets;
    wr(3'd2, 8'hC1);
    check("R4", "fifo ctrl write", {8'h0, fifo_ctrl}, 16'h00C1);
    rd_chk("R4", "ident read at offset 2", 3'd2, 8'h01);
    wr(3'd3, 8'h83);
    wr(3'd2, 8'h07);
    check("R4", "fifo ctrl under overlay", {8'h0, fifo_ctrl}, 16'h0007);
    rd_chk("R4", "ident under overlay", 3'd2, 8'h01);
    rd_chk("R5", "scratch under overlay", 3'd7, 8'h00);
    wr(3'd3, 8'h03);
    wr(3'd4, 8'hFF);
    rd_chk("R5", "modem ctrl 5 bits", 3'd4, 8'h1F);
    wr(3'd4, 8'h00);
    wr(3'd7, 8'hA5);
    rd_chk("R5", "scratch readback", 3'd7, 8'hA5);
    wr(3'd5, 8'h00);
    rd_chk("R5", "line status write ignored", 3'd5, 8'h60);
    wr(3'd6, 8'hFF);
    rd_chk("R5", "modem status write ignored", 3'd6, 8'h00);
  endtask

  task automatic t_rx;
    rx_push(8'h3C, 1'b0);
    rd_chk("R7", "data ready set", 3'd5, 8'h61);
    rd_chk("R1", "rx buffer read", 3'd0, 8'h3C);
    rd_chk("R7", "data ready cleared", 3'd5, 8'h60);
    rx_push(8'h11, 1'b0);
    rx_push(8'h22, 1'b1);
    rd_chk("R7", "overrun and parity", 3'd5, 8'h67);
    rd_chk("R10", "errors cleared by read", 3'd5, 8'h61);
    rd_chk("R1", "latest byte kept", 3'd0, 8'h22);
  endtask

  task automatic t_tx;
    int base;
    base = tx_cnt;
    @(negedge clk); tx_ready = 1'b0;
    wr(3'd0, 8'h5A);
    rd_chk("R8", "holding and shifter not empty", 3'd5, 8'h00);
    check("R8", "no load while not ready", tx_cnt - base, 0);
    @(negedge clk); tx_ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R8", "single load pulse", tx_cnt - base, 1);
    check("R1", "loaded byte", {8'h0, tx_last}, 16'h005A);
    rd_chk("R8", "empty again", 3'd5, 8'h60);
  endtask

  task automatic t_msr;
    @(negedge clk); modem_in = 4'b0001;
    rd_chk("R10", "cts rise", 3'd6, 8'h11);
    rd_chk("R10", "cts delta cleared", 3'd6, 8'h10);
    @(negedge clk); modem_in = 4'b0101;
    rd_chk("R10", "ring rise no delta", 3'd6, 8'h50);
    @(negedge clk); modem_in = 4'b0001;
    rd_chk("R10", "ring fall delta", 3'd6, 8'h14);
    @(negedge clk); modem_in = 4'b0000;
    rd_chk("R10", "cts fall delta", 3'd6, 8'h01);
    rd_chk("R10", "all cleared", 3'd6, 8'h00);
  endtask

  task automatic t_prio;
    int base;
    wr(3'd1, 8'h0F);
    rd_chk("R9", "holding empty id", 3'd2, 8'h02);
    wr(3'd4, 8'h08);
    @(negedge clk);
    check("R6", "irq with gate set", {15'h0, irq}, 16'h1);
    rx_push(8'h41, 1'b0);
    rd_chk("R9", "rx data id", 3'd2, 8'h04);
    rx_push(8'h42, 1'b0);
    rd_chk("R9", "line status id first", 3'd2, 8'h06);
    rd_chk("R7", "overrun seen", 3'd5, 8'h63);
    rd_chk("R9", "rx data id after clear", 3'd2, 8'h04);
    rd_chk("R1", "second byte", 3'd0, 8'h42);
    rd_chk("R9", "holding empty id again", 3'd2, 8'h02);
    @(negedge clk); modem_in = 4'b0001; tx_ready = 1'b0;
    wr(3'd0, 8'h77);
    rd_chk("R9", "modem id last", 3'd2, 8'h00);
    rd_chk("R10", "modem status", 3'd6, 8'h11);
    rd_chk("R9", "nothing pending", 3'd2, 8'h01);
    check("R6", "irq low when idle", {15'h0, irq}, 16'h0);
    base = tx_cnt;
    @(negedge clk); tx_ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R8", "queued byte sent", tx_cnt - base, 1);
    check("R6", "irq on holding empty", {15'h0, irq}, 16'h1);
    wr(3'd4, 8'h00);
    @(negedge clk);
    check("R6", "irq gated off", {15'h0, irq}, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_divisor();
    t_offsets();
    t_rx();
    t_tx();
    t_msr();
    t_prio();
    rd_chk("R12", "scratch still held", 3'd7, 8'hA5);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule